// File: doc/BRIEF.md
# I2C Configuration Target with General-Call Reset

This block is the serial front end of a configuration register device. It watches the two bus lines with the system clock and recognises bus start and stop conditions. It accepts its own 7-bit address and moves bytes between the bus and a small external register port. The upper six address bits are a fixed parameter. The lowest bit comes from a board-level strap input, so two such devices can share one bus.

On a write, the first data byte sets the register pointer. Every later byte is written to the pointed register, and the pointer then advances. On a read, the register at the pointer is sent out most significant bit first. The master acknowledges each byte to ask for the next one, or leaves the bit high to end the read.

Two special first bytes are handled:
- **General-call reset.** A 00h address followed by the command 06h is acknowledged and produces a single-cycle reset pulse.
- **High-speed master code.** A first byte of the form 00001xxx is deliberately left unacknowledged. It raises a high-speed flag that holds until the next stop condition.

The block never drives the clock line. It drives the data line only low, or releases it.

Top module: `i2c_cfg_target`

## Requirements
- R1: A START (data falling while clock high) restarts address reception from any state. A repeated START keeps the register pointer. A STOP (data rising while clock high) returns the block to idle and releases the data line.
- R2: An address byte whose upper seven bits equal 1110100 with the last bit replaced by `addr_strap` is acknowledged on the ninth clock. Bit 0 of that byte selects read (1) or write (0).
- R3: Any other address, apart from the general-call and high-speed codes, gets no acknowledge. No register is written, and the data line stays released until the next START or STOP.
- R4: In a write, the first data byte loads `reg_ptr`. Each later byte is written to `reg_ptr` with a one-cycle `reg_wr`, after which `reg_ptr` advances by one and wraps at its width. Every byte is acknowledged.
- R5: In a read, the register at `reg_ptr` is shifted out MSB first and `reg_ptr` advances once per byte sent. A low ninth bit from the master requests another byte. A high ninth bit ends the read and leaves the data line released.
- R6: A first byte of 00h followed by 06h has both bytes acknowledged and produces exactly one `gc_reset` pulse of one clock cycle. 00h followed by any other byte leaves the second byte unacknowledged and produces no pulse.
- R7: A first byte matching 00001xxx is not acknowledged and sets `hs_active`. The flag stays set across repeated STARTs and clears at STOP.
- R8: A pulse on either bus line that lasts a single system clock is filtered out and disturbs neither bits nor conditions.
- R9: `sda_drive_low` changes only while the filtered clock line is low, apart from a release caused by a START or STOP.
- R10: After reset, `sda_drive_low`, `gc_reset`, `hs_active` and `reg_wr` are 0, and `reg_ptr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 1 | Strap giving the lowest address bit |
| sda_drive_low | output | 1 | 1 pulls the data line low, 0 releases it |
| gc_reset | output | 1 | One-cycle pulse on a general-call reset |
| hs_active | output | 1 | High-speed master code seen, held until STOP |
| reg_ptr | output | PTR_W | Register pointer, used for both reads and writes |
| reg_wdata | output | 8 | Byte to write |
| reg_wr | output | 1 | One-cycle write strobe for `reg_ptr` |
| reg_rdata | input | 8 | Register contents at `reg_ptr` |

## Verification
The following properties are checked on every cycle:
- the data-line drive changes only during the clock-low phase;
- a START or STOP forces the release and state change that follow it;
- the reset pulse lasts a single cycle;
- each write strobe is followed by a pointer step;
- the high-speed flag rises with no acknowledge pending;
- the filtered lines change only after two agreeing samples.

Other behaviour can only be shown by the bench's bus transactions:
- which of all 128 addresses are acknowledged, under both strap levels;
- that the data bytes land in the right registers and read back in order;
- that a repeated START keeps the pointer;
- that single-cycle glitches leave a transfer intact.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } tgt_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    localparam logic [7:0] GCALL_BYTE      = 8'h00;
    localparam logic [7:0] GCALL_RESET_CMD = 8'h06;
    localparam logic [4:0] HS_CODE_TOP     = 5'b00001;

    function automatic logic own_addr(input logic [7:0] b, input logic [5:0] prefix,
                                      input logic strap);
        return b[7:1] == {prefix, strap};
    endfunction

    function automatic logic is_gcall(input logic [7:0] b);
        return b == GCALL_BYTE;
    endfunction

    function automatic logic is_hs_code(input logic [7:0] b);
        return b[7:3] == HS_CODE_TOP;
    endfunction

endpackage

// File: rtl/i2ct_filter.sv
module i2ct_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] sync_q;
    logic         last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            last_q <= 1'b1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[TOP-1:0], din};
            last_q <= sync_q[TOP];
            // accept a new level only after two equal consecutive samples
            if (sync_q[TOP] == last_q && last_q != dout)
                dout <= last_q;
        end
    end

    a_r8_filter_agree: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout) |-> ($past(sync_q[TOP]) == dout && $past(last_q) == dout));

endmodule

// File: rtl/i2ct_busevents.sv
module i2ct_busevents
    import i2ct_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.start = scl_f && scl_q &&  sda_q && !sda_f;
        ev.stop  = scl_f && scl_q && !sda_q &&  sda_f;
        ev.rise  = scl_f && !scl_q;
        ev.fall  = !scl_f && scl_q;
    end

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
    import i2ct_pkg::*;
#(
    parameter logic [5:0] ADDR_PREFIX = 6'b111010,
    parameter int         PTR_W       = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             addr_strap,
    output logic             sda_drive_low,
    output logic             gc_reset,
    output logic             hs_active,
    output logic [PTR_W-1:0] reg_ptr,
    output logic [7:0]       reg_wdata,
    output logic             reg_wr,
    input  logic [7:0]       reg_rdata
);
    localparam int NBITS = 8;
    localparam int CNT_W = $clog2(NBITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NBITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NBITS - 1);

    // line 0 = clock, line 1 = data
    logic [1:0] raw_lines, filt_lines;
    logic       scl_f, sda_f;
    bus_ev_t    ev;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2ct_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_lines[g]),
            .dout (filt_lines[g])
        );
    end

    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    i2ct_busevents u_ev (
        .clk   (clk),
        .rst   (rst),
        .scl_f (scl_f),
        .sda_f (sda_f),
        .ev    (ev)
    );

    tgt_state_t       st;
    logic [7:0]       shreg;
    logic [CNT_W-1:0] cnt;
    logic             rd_mode, gc_mode, gc_done, ptr_loaded, master_ack, drive_q;

    assign sda_drive_low = drive_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            shreg      <= '0;
            cnt        <= '0;
            rd_mode    <= 1'b0;
            gc_mode    <= 1'b0;
            gc_done    <= 1'b0;
            ptr_loaded <= 1'b0;
            master_ack <= 1'b0;
            drive_q    <= 1'b0;
            gc_reset   <= 1'b0;
            hs_active  <= 1'b0;
            reg_ptr    <= '0;
            reg_wdata  <= '0;
            reg_wr     <= 1'b0;
        end else begin
            reg_wr   <= 1'b0;
            gc_reset <= 1'b0;
            if (reg_wr)
                reg_ptr <= reg_ptr + 1'b1;

            if (ev.start) begin
                st      <= ST_ADDR;
                cnt     <= '0;
                drive_q <= 1'b0;
            end else if (ev.stop) begin
                st        <= ST_IDLE;
                drive_q   <= 1'b0;
                hs_active <= 1'b0;
            end else begin
                unique case (st)
                    ST_ADDR: begin
                        if (ev.rise && cnt != CNT_FULL) begin
                            shreg <= {shreg[6:0], sda_f};
                            cnt   <= cnt + 1'b1;
                        end else if (ev.fall && cnt == CNT_FULL) begin
                            if (own_addr(shreg, ADDR_PREFIX, addr_strap)) begin
                                drive_q    <= 1'b1;
                                st         <= ST_ACK;
                                rd_mode    <= shreg[0];
                                gc_mode    <= 1'b0;
                                gc_done    <= 1'b0;
                                ptr_loaded <= 1'b0;
                            end else if (is_gcall(shreg)) begin
                                drive_q <= 1'b1;
                                st      <= ST_ACK;
                                rd_mode <= 1'b0;
                                gc_mode <= 1'b1;
                                gc_done <= 1'b0;
                            end else begin
                                if (is_hs_code(shreg))
                                    hs_active <= 1'b1;
                                st <= ST_SKIP;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev.fall) begin
                            cnt <= '0;
                            if (gc_done) begin
                                drive_q <= 1'b0;
                                st      <= ST_SKIP;
                            end else if (rd_mode) begin
                                shreg   <= reg_rdata;
                                reg_ptr <= reg_ptr + 1'b1;
                                drive_q <= ~reg_rdata[7];
                                st      <= ST_RDATA;
                            end else begin
                                drive_q <= 1'b0;
                                st      <= ST_WDATA;
                            end
                        end
                    end
                    ST_WDATA: begin
                        if (ev.rise && cnt != CNT_FULL) begin
                            shreg <= {shreg[6:0], sda_f};
                            cnt   <= cnt + 1'b1;
                        end else if (ev.fall && cnt == CNT_FULL) begin
                            if (gc_mode) begin
                                if (shreg == GCALL_RESET_CMD) begin
                                    gc_reset <= 1'b1;
                                    gc_done  <= 1'b1;
                                    drive_q  <= 1'b1;
                                    st       <= ST_ACK;
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end else begin
                                if (!ptr_loaded) begin
                                    reg_ptr    <= shreg[PTR_W-1:0];
                                    ptr_loaded <= 1'b1;
                                end else begin
                                    reg_wdata <= shreg;
                                    reg_wr    <= 1'b1;
                                end
                                drive_q <= 1'b1;
                                st      <= ST_ACK;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (ev.fall) begin
                            if (cnt == CNT_LAST) begin
                                drive_q <= 1'b0;
                                st      <= ST_RACK;
                            end else begin
                                shreg   <= {shreg[6:0], 1'b0};
                                drive_q <= ~shreg[6];
                                cnt     <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.rise) begin
                            master_ack <= ~sda_f;
                        end else if (ev.fall) begin
                            if (master_ack) begin
                                shreg   <= reg_rdata;
                                reg_ptr <= reg_ptr + 1'b1;
                                drive_q <= ~reg_rdata[7];
                                cnt     <= '0;
                                st      <= ST_RDATA;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r1_start_to_addr: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (st == ST_ADDR && !sda_drive_low));

    a_r1_stop_release: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (!sda_drive_low && !hs_active && st == ST_IDLE));

    a_r6_gc_single: assert property (@(posedge clk) disable iff (rst)
        gc_reset |=> !gc_reset);

    a_r4_ptr_step: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (reg_ptr == $past(reg_ptr) + 1'b1 && !reg_wr));

    a_r7_hs_no_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_active) |-> !sda_drive_low);

    a_r9_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_drive_low) && !$past(ev.start || ev.stop)) |-> !$past(scl_f));

endmodule

// File: tb/i2c_cfg_target_test.sv
`timescale 1ns/1ps
module i2c_cfg_target_test;
    localparam int PTR_W = 4;
    localparam int Q     = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
    logic sda_oe, gc_reset, hs_active, reg_wr;
    logic [PTR_W-1:0] reg_ptr;
    logic [7:0] reg_wdata, reg_rdata;
    logic sda_line;
    logic [7:0] mem [16];
    int checks = 0, errors = 0, gc_pulses = 0, wr_count = 0, r9_viol = 0, scl_hi_run = 0;
    logic prev_oe = 1'b0;

    always #4 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_ptr];

    i2c_cfg_target #(.PTR_W(PTR_W)) uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .addr_strap(strap),
        .sda_drive_low(sda_oe), .gc_reset(gc_reset), .hs_active(hs_active),
        .reg_ptr(reg_ptr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 16; k++) mem[k] <= 8'h00;
            gc_pulses  <= 0;
            wr_count   <= 0;
            r9_viol    <= 0;
            scl_hi_run <= 0;
            prev_oe    <= 1'b0;
        end else begin
            if (reg_wr) begin
                mem[reg_ptr] <= reg_wdata;
                wr_count     <= wr_count + 1;
            end
            if (gc_reset) gc_pulses <= gc_pulses + 1;
            scl_hi_run <= scl_m ? scl_hi_run + 1 : 0;
            prev_oe    <= sda_oe;
            if (sda_oe != prev_oe && scl_hi_run > 6) r9_viol <= r9_viol + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wt(2*Q);
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b0;
    endtask

    task automatic bus_rstart();
        wt(Q); sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wt(Q);
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wt(Q); sda_m = 1'b0; wt(Q);
        scl_m = 1'b1; wt(Q);
        sda_m = 1'b1; wt(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            wt(Q); sda_m = b[i]; wt(Q);
            scl_m = 1'b1; wt(Q);
            if (glitch) begin
                sda_m = ~sda_m; wt(1); sda_m = ~sda_m;
                scl_m = 1'b0;   wt(1); scl_m = 1'b1;
                wt(Q - 2);
            end else begin
                wt(Q);
            end
            scl_m = 1'b0;
        end
        wt(Q); sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wt(Q);
        ack = !sda_line; wt(Q);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(2*Q); scl_m = 1'b1; wt(Q);
            b[i] = sda_line; wt(Q);
            scl_m = 1'b0;
        end
        wt(Q); sda_m = give_ack ? 1'b0 : 1'b1; wt(Q);
        scl_m = 1'b1; wt(2*Q);
        scl_m = 1'b0; wt(Q);
        sda_m = 1'b1;
    endtask

    initial begin
        wt(190000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] rb;
        int p0, w0;
        wt(5); rst = 1'b0; wt(3);
        // R10 reset state
        chk(sda_oe == 1'b0, "R10 drive", sda_oe, 0);
        chk(gc_reset == 1'b0, "R10 gc_reset", gc_reset, 0);
        chk(hs_active == 1'b0, "R10 hs_active", hs_active, 0);
        chk(reg_wr == 1'b0, "R10 reg_wr", reg_wr, 0);
        chk(reg_ptr == 0, "R10 reg_ptr", reg_ptr, 0);

        // R2, R4: write three bytes from pointer 3
        bus_start();
        send_byte(8'hE8, 0, ack); chk(ack, "R2 address 74h ack", ack, 1);
        send_byte(8'h03, 0, ack); chk(ack, "R4 pointer byte ack", ack, 1);
        send_byte(8'hA5, 0, ack); chk(ack, "R4 data ack", ack, 1);
        send_byte(8'h5A, 0, ack); chk(ack, "R4 data ack", ack, 1);
        send_byte(8'hFF, 0, ack); chk(ack, "R4 data ack", ack, 1);
        bus_stop();
        chk(reg_ptr == 6, "R4 pointer advanced", reg_ptr, 6);
        chk(mem[3] == 8'hA5 && mem[4] == 8'h5A && mem[5] == 8'hFF, "R4 register contents",
            {mem[3], mem[4], mem[5]}, 24'hA55AFF);

        // R5, R1: set pointer, repeated start, read with ack, ack, nack
        bus_start();
        send_byte(8'hE8, 0, ack);
        send_byte(8'h03, 0, ack);
        bus_rstart();
        send_byte(8'hE9, 0, ack); chk(ack, "R2 read address ack", ack, 1);
        recv_byte(1, rb); chk(rb == 8'hA5, "R5 read byte 0", rb, 8'hA5);
        recv_byte(1, rb); chk(rb == 8'h5A, "R5 read byte 1", rb, 8'h5A);
        recv_byte(0, rb); chk(rb == 8'hFF, "R5 read byte 2", rb, 8'hFF);
        chk(sda_oe == 1'b0, "R5 release after nack", sda_oe, 0);
        bus_stop();
        chk(reg_ptr == 6, "R5 pointer after read", reg_ptr, 6);

        // R1: pointer retained across repeated START
        bus_start();
        send_byte(8'hE8, 0, ack); send_byte(8'h07, 0, ack); send_byte(8'h3C, 0, ack);
        bus_stop();
        bus_start();
        send_byte(8'hE8, 0, ack); send_byte(8'h07, 0, ack);
        bus_rstart();
        send_byte(8'hE9, 0, ack);
        recv_byte(0, rb); chk(rb == 8'h3C, "R1 repeated start keeps pointer", rb, 8'h3C);
        bus_stop();
        chk(reg_ptr == 8, "R1 pointer value", reg_ptr, 8);

        // R3: mismatched address ignored
        w0 = wr_count;
        bus_start();
        send_byte(8'h66, 0, ack); chk(!ack, "R3 mismatch nack", ack, 0);
        send_byte(8'h01, 0, ack); chk(!ack, "R3 data nack", ack, 0);
        send_byte(8'h99, 0, ack); chk(!ack, "R3 data nack", ack, 0);
        bus_stop();
        chk(wr_count == w0, "R3 no writes", wr_count, w0);
        chk(reg_ptr == 8, "R3 pointer kept", reg_ptr, 8);

        // R6: general-call reset and a wrong command
        p0 = gc_pulses;
        bus_start();
        send_byte(8'h00, 0, ack); chk(ack, "R6 general call ack", ack, 1);
        send_byte(8'h06, 0, ack); chk(ack, "R6 reset command ack", ack, 1);
        bus_stop();
        chk(gc_pulses == p0 + 1, "R6 one pulse", gc_pulses, p0 + 1);
        bus_start();
        send_byte(8'h00, 0, ack);
        send_byte(8'h07, 0, ack); chk(!ack, "R6 other command nack", ack, 0);
        bus_stop();
        chk(gc_pulses == p0 + 1, "R6 no pulse on other command", gc_pulses, p0 + 1);
        chk(wr_count == w0 && reg_ptr == 8, "R6 no register effect", reg_ptr, 8);

        // R7: high-speed master code
        bus_start();
        send_byte(8'h0A, 0, ack); chk(!ack, "R7 code not acked", ack, 0);
        chk(hs_active, "R7 flag set", hs_active, 1);
        bus_rstart();
        send_byte(8'hE8, 0, ack); chk(ack, "R7 address after code", ack, 1);
        chk(hs_active, "R7 flag kept over restart", hs_active, 1);
        bus_stop();
        chk(!hs_active, "R7 flag cleared at stop", hs_active, 0);

        // R8: one-cycle glitches on both lines during every bit
        bus_start();
        send_byte(8'hE8, 1, ack); chk(ack, "R8 glitched address ack", ack, 1);
        send_byte(8'h0C, 1, ack); chk(ack, "R8 glitched pointer ack", ack, 1);
        send_byte(8'h77, 1, ack); chk(ack, "R8 glitched data ack", ack, 1);
        bus_stop();
        chk(mem[12] == 8'h77, "R8 glitched write", mem[12], 8'h77);

        // R4: pointer wrap
        bus_start();
        send_byte(8'hE8, 0, ack); send_byte(8'h0F, 0, ack);
        send_byte(8'h11, 0, ack); send_byte(8'h22, 0, ack);
        bus_stop();
        chk(mem[15] == 8'h11 && mem[0] == 8'h22, "R4 wrap write", {mem[15], mem[0]}, 16'h1122);
        chk(reg_ptr == 1, "R4 wrap pointer", reg_ptr, 1);

        // R2, R3, R6, R7: sweep every address under both strap levels
        for (int s = 0; s < 2; s++) begin
            strap = s[0];
            wt(4);
            for (int a = 0; a < 128; a++) begin
                logic [6:0] av;
                bit exp_ack, exp_hs;
                av = a[6:0];
                exp_ack = (av == {6'b111010, s[0]}) || (av == 7'd0);
                exp_hs  = (av[6:2] == 5'b00001);
                bus_start();
                send_byte({av, 1'b0}, 0, ack);
                chk(ack == exp_ack, "R2/R3 sweep ack", {s[7:0], 1'b0, av, 7'd0, ack}, {s[7:0], 1'b0, av, 7'd0, exp_ack});
                chk(hs_active == exp_hs, "R7 sweep flag", {av, hs_active}, {av, exp_hs});
                bus_stop();
            end
        end
        chk(gc_pulses == p0 + 1, "R6 no pulse without command", gc_pulses, p0 + 1);
        chk(r9_viol == 0, "R9 drive changed during clock high", r9_viol, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule